// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the word address that a synchronous SRAM array uses during a burst. A master presents one external address and then, on each following clock, either advances the burst or loads a new address. The sequencer captures the address and the burst-order select together on a load. On each advance it steps only the low beat bits. The upper bits stay fixed. The beat bits step either in wrapping linear order (start plus beat count) or in interleaved order (start XOR beat count). A load with the chip deselected ends the burst. A clock enable that is sampled inactive freezes the whole block.

Control is a two-state machine. ST_IDLE means no burst and ST_BURST means a burst is running. The transitions are:
- `ld_sel` goes from either state to ST_BURST.
- `ld_desel` goes from either state to ST_IDLE.
- `step` keeps ST_BURST.
- `freeze` (clock enable inactive) keeps the current state.
- `idle_adv` (an advance with no burst) keeps ST_IDLE.

The state machine decodes these into one operation code. A beat counter and an address mapper act on that code.

Top module: `bseq_top`

## Requirements
- R1: After reset, `burst_on` is 0 and `word_addr` is all zeros.
- R2: When `cke_n`=0, `ld_n`=0 and `sel`=1 at an edge, after that edge `word_addr` equals the sampled `ext_addr` and `burst_on` is 1. This holds even when a burst is already running, in which case the burst restarts.
- R3: With `order_ilv`=0 captured at the load, each advance makes bits [1:0] of `word_addr` equal (start + n) mod 4. Here start is the loaded bits [1:0] and n is the number of advances since the load.
- R4: With `order_ilv`=1 captured at the load, each advance makes bits [1:0] equal start XOR n, where n counts modulo 4.
- R5: During advances, `word_addr` bits above bit 1 never change.
- R6: On an advance (`ld_n`=1), `ext_addr` has no effect on `word_addr`.
- R7: The fifth beat (fourth advance) wraps back to the start address, and `burst_on` stays 1.
- R8: When `cke_n`=0, `ld_n`=0 and `sel`=0 at an edge, the burst ends. `burst_on` becomes 0, `word_addr` returns to the loaded start address, and `ext_addr` is not captured.
- R9: When `cke_n`=1 at an edge, `word_addr` and `burst_on` keep their values whatever the other inputs are.
- R10: `order_ilv` is used only at a load. Changing it in the middle of a burst does not alter the sequence.
- R11: An advance while `burst_on`=0 leaves `word_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke_n | input | 1 | Clock enable, active low; when high, the edge is ignored |
| ld_n | input | 1 | Low: load or deselect; high: advance |
| sel | input | 1 | Chip-select qualifier, qualified together with ld_n |
| order_ilv | input | 1 | Burst order: 1 selects interleaved, 0 selects linear |
| ext_addr | input | ADDR_W | External word address |
| word_addr | output | ADDR_W | Current word address to the array |
| burst_on | output | 1 | A burst is in progress |

## Verification
The bench builds the block with ADDR_W=10 and BEAT_W=2. With these values the four-beat group and its wrap are reached within a handful of cycles. The ten-bit width still leaves eight upper bits that can differ from the lower ones and from noisy `ext_addr` values, so a leaking upper bit shows up. Start offsets of 1 and 2 are used so that linear and interleaved sequences visibly diverge. Freeze, deselect and mid-burst order changes are applied inside running bursts.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } bseq_state_e;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_STOP = 2'd2,
        OP_STEP = 2'd3
    } bseq_op_e;
endpackage

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
    import bseq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cke_n,
    input  logic     ld_n,
    input  logic     sel,
    output bseq_op_e op,
    output logic     burst_on
);
    bseq_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!cke_n) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (!ld_n && sel) state_d = ST_BURST;  // ld_sel
                    else              state_d = ST_IDLE;   // ld_desel, idle_adv
                end
                ST_BURST: begin
                    if (!ld_n && !sel) state_d = ST_IDLE;  // ld_desel
                    else               state_d = ST_BURST; // ld_sel, step
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        op       = OP_HOLD;
        burst_on = (state_q == ST_BURST);
        if (!cke_n) begin
            if (!ld_n)                      op = sel ? OP_LOAD : OP_STOP;
            else if (state_q == ST_BURST)   op = OP_STEP;
            else                            op = OP_HOLD;
        end
    end

    // R8
    desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !ld_n && !sel) |=> !burst_on);

    // R9
    freeze_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> $stable(burst_on));
endmodule

// File: rtl/bseq_beat.sv
module bseq_beat
    import bseq_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bseq_op_e          op,
    output logic [BEAT_W-1:0] beat
);
    localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat <= '0;
        end else begin
            unique case (op)
                OP_LOAD, OP_STOP: beat <= '0;
                OP_STEP:          beat <= beat + ONE;
                default:          beat <= beat;
            endcase
        end
    end

    // R7
    beat_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_STEP && beat == '1) |=> beat == '0);
endmodule

// File: rtl/bseq_map.sv
module bseq_map
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bseq_op_e          op,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              order_ilv,
    input  logic [BEAT_W-1:0] beat,
    output logic [ADDR_W-1:0] word_addr
);
    localparam int HI_W = ADDR_W - BEAT_W;

    logic [ADDR_W-1:0] base_q;
    logic              ilv_q;
    logic [BEAT_W-1:0] start, lo;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            ilv_q  <= 1'b0;
        end else if (op == OP_LOAD) begin
            base_q <= ext_addr;
            ilv_q  <= order_ilv;
        end
    end

    assign start = base_q[BEAT_W-1:0];

    always_comb begin
        if (ilv_q) lo = start ^ beat;
        else       lo = start + beat;
    end

    generate
        if (HI_W > 0) begin : g_hi
            assign word_addr = {base_q[ADDR_W-1:BEAT_W], lo};
        end else begin : g_nohi
            assign word_addr = lo;
        end
    endgenerate

    // R3
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_STEP && !ilv_q) |=>
            word_addr[BEAT_W-1:0] == $past(word_addr[BEAT_W-1:0]) + BEAT_W'(1));

    // R4
    ilv_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_STEP && ilv_q && beat == '0) |=>
            word_addr[BEAT_W-1:0] == ($past(word_addr[BEAT_W-1:0]) ^ BEAT_W'(1)));
endmodule

// File: rtl/bseq_top.sv
module bseq_top
    import bseq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke_n,
    input  logic              ld_n,
    input  logic              sel,
    input  logic              order_ilv,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] word_addr,
    output logic              burst_on
);
    bseq_op_e          op;
    logic [BEAT_W-1:0] beat;

    bseq_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cke_n    (cke_n),
        .ld_n     (ld_n),
        .sel      (sel),
        .op       (op),
        .burst_on (burst_on)
    );

    bseq_beat #(.BEAT_W(BEAT_W)) u_beat (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .beat  (beat)
    );

    bseq_map #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .ext_addr  (ext_addr),
        .order_ilv (order_ilv),
        .beat      (beat),
        .word_addr (word_addr)
    );

    // R2
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && !ld_n && sel) |=> (word_addr == $past(ext_addr)) && burst_on);

    // R5
    upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && ld_n) |=>
            word_addr[ADDR_W-1:BEAT_W] == $past(word_addr[ADDR_W-1:BEAT_W]));

    // R9
    freeze_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cke_n |=> $stable(word_addr));

    // R11
    idle_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke_n && ld_n && !burst_on) |=> $stable(word_addr));
endmodule

// File: tb/sim_bseq_top.sv
module sim_bseq_top;
    localparam int AW = 10;
    localparam int BW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cke_n = 1'b1;
    logic          ld_n = 1'b1;
    logic          sel = 1'b0;
    logic          order_ilv = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic [AW-1:0] word_addr;
    logic          burst_on;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [AW-1:0] q_addr[$];
    logic          q_on[$];
    string         q_tag[$];

    logic [AW-1:0] m_base = '0;
    logic [BW-1:0] m_beat = '0;
    logic          m_on = 1'b0;
    logic          m_ilv = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    bseq_top #(.ADDR_W(AW), .BEAT_W(BW)) u0 (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .ld_n(ld_n), .sel(sel),
        .order_ilv(order_ilv), .ext_addr(ext_addr),
        .word_addr(word_addr), .burst_on(burst_on)
    );

    function automatic logic [AW-1:0] model_addr();
        logic [BW-1:0] lo;
        lo = m_ilv ? (m_base[BW-1:0] ^ m_beat) : (m_base[BW-1:0] + m_beat);
        return {m_base[AW-1:BW], lo};
    endfunction

    task automatic apply(input logic c, input logic l, input logic s,
                         input logic o, input logic [AW-1:0] a, input string tag);
        @(negedge clk);
        cke_n = c; ld_n = l; sel = s; order_ilv = o; ext_addr = a;
        if (!c) begin
            if (!l && s) begin
                m_base = a; m_ilv = o; m_beat = '0; m_on = 1'b1;
            end else if (!l) begin
                m_on = 1'b0; m_beat = '0;
            end else if (m_on) begin
                m_beat = m_beat + 1'b1;
            end
        end
        q_addr.push_back(model_addr());
        q_on.push_back(m_on);
        q_tag.push_back(tag);
    endtask

    // monitor: samples 5 ns after each rising edge
    always @(posedge clk) begin
        #5;
        if (q_addr.size() > 0) begin
            logic [AW-1:0] ea;
            logic          eo;
            string         t;
            ea = q_addr.pop_front();
            eo = q_on.pop_front();
            t  = q_tag.pop_front();
            n_chk++;
            if (word_addr !== ea || burst_on !== eo) begin
                n_bad++;
                $display("FAIL %s: addr=%h on=%b expected addr=%h on=%b",
                         t, word_addr, burst_on, ea, eo);
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        n_chk++;
        if (word_addr !== '0 || burst_on !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: addr=%h on=%b expected addr=000 on=0", word_addr, burst_on);
        end
        rst_n = 1'b1;

        apply(0, 1, 1, 0, 10'h3FF, "R11");          // advance with no burst
        apply(0, 0, 1, 0, 10'h2A5, "R2");           // linear load, start 01
        apply(0, 1, 1, 0, 10'h15A, "R3 R5 R6");     // 10
        apply(0, 1, 0, 0, 10'h0FF, "R3 R6");        // 11
        apply(0, 1, 1, 1, 10'h000, "R3 R10");       // 00, order pin flipped
        apply(0, 1, 1, 0, 10'h3C3, "R7");           // wrap to 01
        apply(1, 0, 1, 1, 10'h111, "R9");           // frozen load
        apply(1, 1, 1, 0, 10'h222, "R9");           // frozen step
        apply(0, 1, 1, 0, 10'h333, "R3");           // 10
        apply(0, 0, 1, 1, 10'h0F6, "R2");           // ilv load, start 10
        apply(0, 1, 1, 1, 10'h001, "R4 R5");        // 11
        apply(0, 1, 1, 0, 10'h002, "R4 R10");       // 00
        apply(0, 1, 1, 1, 10'h3FD, "R4");           // 01
        apply(0, 1, 1, 1, 10'h3FE, "R7");           // back to 10
        apply(0, 0, 1, 0, 10'h081, "R2");           // restart mid-burst
        apply(0, 1, 1, 0, 10'h000, "R3");
        apply(0, 0, 0, 1, 10'h2FF, "R8");           // deselect ends burst
        apply(0, 1, 1, 1, 10'h123, "R8 R11");       // advance ignored
        apply(1, 0, 1, 0, 10'h3AA, "R9");           // frozen while idle
        apply(0, 0, 1, 1, 10'h1FD, "R2");           // ilv start 01
        apply(0, 1, 1, 1, 10'h000, "R4");           // 00
        apply(0, 1, 1, 1, 10'h000, "R4");           // 11
        apply(0, 1, 1, 1, 10'h000, "R4");           // 10
        apply(0, 1, 1, 1, 10'h000, "R7");           // 01
        apply(0, 1, 1, 1, 10'h000, "R4");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule